// File: doc/BRIEF.md
# I2C Controller Status and Event-Flag Register

This block holds the 8-bit status word of an I2C controller. It takes the raw SCL and SDA bus levels and passes each through its own synchronizer. From the synchronized samples it detects start and stop conditions and SCL edges. From these it keeps a bus-occupied indication, and in master-transmit mode it detects lost arbitration. The controller core feeds it side-band strobes: address matches, end of a byte transfer, receiver acknowledge samples and data-register accesses. From these the block raises an interrupt request, the address-match flags and the acknowledge bit.

The CPU reads the status word through a registered read port. A read arms each event flag that it returned as 1. A later write of 0 to that bit clears the flag. Writing 1 to an event flag has no effect. Writing 0 without a prior read also has no effect. A write with the condition-inhibit bit at 0 sends the core a one-cycle request. The request is a start when the busy bit is written as 1 and a stop when it is written as 0.

Top module: `i2c_status_reg`

## Requirements
- R1: The status word, from bit 7 to bit 0, is: busy, interrupt request, condition-inhibit, spare, arbitration lost, address matched, general call matched, acknowledge. A read returns it on `cpu_rdata` one cycle after `cpu_rd`, and bits 5 and 4 always read as 1.
- R2: After reset every flag and the acknowledge bit are 0, so a read returns 8'h30.
- R3: Busy goes to 1 when SDA falls while SCL is high (start). It goes to 0 when SDA rises while SCL is high (stop).
- R4: A write with bit 5 = 0 pulses `start_req` for one cycle the cycle after the write if bit 7 = 1, or pulses `stop_req` if bit 7 = 0. A write with bit 5 = 1 pulses neither.
- R5: With `is_master` = 1 and `is_transmit` = 1, arbitration lost is set in two cases. One is a rising SCL edge where `sda_drive` differs from the bus SDA. The other is a falling SCL edge while `scl_drive` is 1. No flag is set when the driven and bus levels agree.
- R6: In slave receive mode, `own_addr_hit` or `gcall_hit` sets address matched. `gcall_hit` also sets general call matched.
- R7: Address matched and general call matched are cleared by `dr_write` when `is_transmit` = 1, or by `dr_read` when `is_transmit` = 0.
- R8: The interrupt request, arbitration lost, address matched and general call matched flags clear only when the bit is written as 0 after a read that returned it as 1. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R9: In master mode, `xfer_done` and arbitration loss each set the interrupt request.
- R10: In slave mode with `fmt_sel` = 0, an address match sets the interrupt request, and so does each `xfer_done` from then until a start or stop condition. Without a preceding match, `xfer_done` sets nothing. With `fmt_sel` = 1, every `xfer_done` sets it.
- R11: In transmit mode, `ack_strobe` loads `ack_sample` into the acknowledge bit (1 = not acknowledged) and receive mode ignores it. A CPU write loads bit 0. `ack_out` follows the bit.
- R12: When a hardware set and a CPU clear of a flag fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_line | input | 1 | Raw SCL bus level |
| sda_line | input | 1 | Raw SDA bus level |
| scl_drive | input | 1 | SCL level the controller drives (1 = released) |
| sda_drive | input | 1 | SDA level the controller drives (1 = released) |
| is_master | input | 1 | Controller is bus master |
| is_transmit | input | 1 | Controller is transmitting |
| fmt_sel | input | 1 | Slave interrupt format select |
| own_addr_hit | input | 1 | Own slave address matched (strobe) |
| gcall_hit | input | 1 | General call address matched (strobe) |
| xfer_done | input | 1 | Byte transfer finished (strobe) |
| ack_strobe | input | 1 | Acknowledge sample valid |
| ack_sample | input | 1 | Acknowledge level seen from receiver |
| dr_write | input | 1 | Data register written by CPU |
| dr_read | input | 1 | Data register read by CPU |
| cpu_wr | input | 1 | Status register write |
| cpu_rd | input | 1 | Status register read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| start_req | output | 1 | Start condition request pulse |
| stop_req | output | 1 | Stop condition request pulse |
| irq | output | 1 | Interrupt request level |
| ack_out | output | 1 | Acknowledge bit |

## Verification
The assertions assume that the mode inputs and the driven line levels are steady around each bus edge. They also assume that a start and a stop are never detected in the same cycle, and that address-match strobes arrive only in slave receive mode. The bench changes one bus line at a time and then waits several cycles so that synchronization settles. It sets the modes before it moves SCL, and it pulses each strobe on its own apart from the one deliberate set-versus-clear collision.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W    = 8;
  localparam int NFLAG     = 4;
  localparam int B_BUSY    = 7;
  localparam int B_IRQ     = 6;
  localparam int B_INHIBIT = 5;
  localparam int B_SPARE   = 4;
  localparam int B_ARB     = 3;
  localparam int B_AMATCH  = 2;
  localparam int B_GCALL   = 1;
  localparam int B_ACK     = 0;

  // flag index -> bit position in the status word
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return B_IRQ;
      1:       return B_ARB;
      2:       return B_AMATCH;
      default: return B_GCALL;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
    end else begin
      scl_p     <= scl_s;
      sda_p     <= sda_s;
      start_evt <= scl_s & scl_p & sda_p & ~sda_s;
      stop_evt  <= scl_s & scl_p & ~sda_p & sda_s;
      scl_rise  <= scl_s & ~scl_p;
      scl_fall  <= ~scl_s & scl_p;
    end
  end
endmodule

// File: rtl/i2c_event_flag.sv
module i2c_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (set_i)                       flag_o <= 1'b1;
      else if (hw_clr_i)               flag_o <= 1'b0;
      else if (wr_i && armed && !wbit_i) flag_o <= 1'b0;

      if (wr_i || !flag_o || hw_clr_i) armed <= 1'b0;
      else if (rd_i)                   armed <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_status_reg.sv
module i2c_status_reg
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_line,
  input  logic              sda_line,
  input  logic              scl_drive,
  input  logic              sda_drive,
  input  logic              is_master,
  input  logic              is_transmit,
  input  logic              fmt_sel,
  input  logic              own_addr_hit,
  input  logic              gcall_hit,
  input  logic              xfer_done,
  input  logic              ack_strobe,
  input  logic              ack_sample,
  input  logic              dr_write,
  input  logic              dr_read,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [STAT_W-1:0] cpu_rdata,
  output logic              start_req,
  output logic              stop_req,
  output logic              irq,
  output logic              ack_out
);
  logic scl_s, sda_s;
  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic busy_q, ack_q, sess_q;
  logic addr_evt, arb_evt, irq_evt, match_clr;
  logic [NFLAG-1:0] flag_set, flag_hwclr, flag_q;
  logic [STAT_W-1:0] stat;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .d_in(scl_line), .q_out(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .d_in(sda_line), .q_out(sda_s));

  i2c_bus_events u_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  always_comb begin
    addr_evt  = !is_master && !is_transmit && (own_addr_hit || gcall_hit);
    arb_evt   = is_master && is_transmit &&
                ((scl_rise && (sda_drive != sda_s)) || (scl_fall && scl_drive));
    if (is_master)    irq_evt = xfer_done || arb_evt;
    else if (fmt_sel) irq_evt = xfer_done;
    else              irq_evt = addr_evt || (xfer_done && sess_q);
    match_clr = (dr_write && is_transmit) || (dr_read && !is_transmit);

    flag_set[0]   = irq_evt;
    flag_set[1]   = arb_evt;
    flag_set[2]   = addr_evt;
    flag_set[3]   = addr_evt && gcall_hit;
    flag_hwclr[0] = 1'b0;
    flag_hwclr[1] = 1'b0;
    flag_hwclr[2] = match_clr;
    flag_hwclr[3] = match_clr;
  end

  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      i2c_event_flag u_flag (
        .clk(clk), .rst(rst),
        .set_i(flag_set[g]), .hw_clr_i(flag_hwclr[g]),
        .rd_i(cpu_rd), .wr_i(cpu_wr),
        .wbit_i(cpu_wdata[flag_pos(g)]),
        .flag_o(flag_q[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      sess_q    <= 1'b0;
      ack_q     <= 1'b0;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
      cpu_rdata <= 8'h30;
    end else begin
      if (start_evt)     busy_q <= 1'b1;
      else if (stop_evt) busy_q <= 1'b0;

      if (addr_evt)                   sess_q <= 1'b1;
      else if (start_evt || stop_evt) sess_q <= 1'b0;

      if (ack_strobe && is_transmit) ack_q <= ack_sample;
      else if (cpu_wr)               ack_q <= cpu_wdata[B_ACK];

      start_req <= cpu_wr && !cpu_wdata[B_INHIBIT] &&  cpu_wdata[B_BUSY];
      stop_req  <= cpu_wr && !cpu_wdata[B_INHIBIT] && !cpu_wdata[B_BUSY];

      if (cpu_rd) cpu_rdata <= stat;
    end
  end

  always_comb begin
    stat            = '0;
    stat[B_BUSY]    = busy_q;
    stat[B_INHIBIT] = 1'b1;
    stat[B_SPARE]   = 1'b1;
    stat[B_ACK]     = ack_q;
    for (int i = 0; i < NFLAG; i++) stat[flag_pos(i)] = flag_q[i];
  end

  assign irq     = flag_q[0];
  assign ack_out = ack_q;
endmodule

// File: rtl/i2c_status_chk.sv
module i2c_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic       start_req,
  input logic       stop_req,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       is_master,
  input logic       is_transmit,
  input logic [7:0] stat
);
  p_req_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_req, stop_req}));

  p_start_from_write_r4: assert property (@(posedge clk) disable iff (rst)
    start_req |-> $past(cpu_wr && !cpu_wdata[5] && cpu_wdata[7]));

  p_stop_from_write_r4: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> $past(cpu_wr && !cpu_wdata[5] && !cpu_wdata[7]));

  p_busy_on_start_r3: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> stat[7]);

  p_free_on_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !start_evt) |=> !stat[7]);

  p_irq_clear_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[6]) |-> $past(cpu_wr && !cpu_wdata[6]));

  p_arb_clear_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(stat[3]) |-> $past(cpu_wr && !cpu_wdata[3]));

  p_arb_master_tx_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> $past(is_master && is_transmit));

  p_gcall_with_addr_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[1]) |-> stat[2]);
endmodule

bind i2c_status_reg i2c_status_chk u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .start_req(start_req), .stop_req(stop_req),
  .start_evt(start_evt), .stop_evt(stop_evt),
  .is_master(is_master), .is_transmit(is_transmit), .stat(stat));

// File: tb/i2c_status_reg_test.sv
`timescale 1ns/1ps
module i2c_status_reg_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_line = 1'b1, sda_line = 1'b1, scl_drive = 1'b0, sda_drive = 1'b0;
  logic is_master = 1'b0, is_transmit = 1'b0, fmt_sel = 1'b0;
  logic own_addr_hit = 1'b0, gcall_hit = 1'b0, xfer_done = 1'b0;
  logic ack_strobe = 1'b0, ack_sample = 1'b0, dr_write = 1'b0, dr_read = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic start_req, stop_req, irq, ack_out;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] v;

  always #4 clk = ~clk;

  i2c_status_reg uut (.*);

  function automatic logic [7:0] st(input logic b, i, a, m, g, k);
    return {b, i, 2'b11, a, m, g, k};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic lines(input logic c, input logic d);
    scl_line = c; sda_line = d;
    tick(6);
  endtask

  task automatic readclr(input logic [7:0] w);
    rd(v);
    wr(w);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    rd(v); chk("R2 reset", v, 8'h30);
    chk("R1 spare bits", {6'd0, v[5:4]}, 8'h03);

    // R3 start then stop
    lines(1'b1, 1'b0);
    rd(v); chk("R3 busy on start", v, st(1,0,0,0,0,0));
    lines(1'b1, 1'b1);
    rd(v); chk("R3 free on stop", v, st(0,0,0,0,0,0));

    // R4 requests
    wr(8'h80); chk("R4 start req", {6'd0, start_req, stop_req}, 8'h02);
    wr(8'h00); chk("R4 stop req", {6'd0, start_req, stop_req}, 8'h01);
    wr(8'hB0); chk("R4 inhibited", {6'd0, start_req, stop_req}, 8'h00);

    // R5 SDA mismatch on rising SCL
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    is_master = 1'b1; is_transmit = 1'b1; sda_drive = 1'b1; scl_drive = 1'b0;
    lines(1'b1, 1'b0);
    wr(8'h30);
    rd(v); chk("R5 R8 sda arb, write w/o read kept", v, st(0,1,1,0,0,0));
    chk("R9 irq pin on arb", {7'd0, irq}, 8'h01);
    wr(8'h78);
    rd(v); chk("R8 write of 1 no clear", v, st(0,1,1,0,0,0));
    wr(8'h30);
    rd(v); chk("R8 read then clear", v, st(0,0,0,0,0,0));

    // R5 SCL driven high at fall
    scl_drive = 1'b1;
    lines(1'b0, 1'b0);
    rd(v); chk("R5 scl arb", v, st(0,1,1,0,0,0));
    wr(8'h30);
    rd(v); chk("R8 clear scl arb", v, st(0,0,0,0,0,0));
    scl_drive = 1'b0; sda_drive = 1'b0;
    lines(1'b1, 1'b0);
    rd(v); chk("R5 no arb when matching", v, st(0,0,0,0,0,0));
    lines(1'b0, 1'b0);

    // R9 master transfer end
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    rd(v); chk("R9 master xfer irq", v, st(0,1,0,0,0,0));
    wr(8'h30);
    rd(v); chk("R9 cleared", v, st(0,0,0,0,0,0));

    // R6 R10 slave receive, fmt 0
    is_master = 1'b0; is_transmit = 1'b0; fmt_sel = 1'b0;
    own_addr_hit = 1'b1; tick(1); own_addr_hit = 1'b0;
    rd(v); chk("R6 own addr", v, st(0,1,0,1,0,0));
    wr(8'h3C);
    rd(v); chk("R8 irq only cleared", v, st(0,0,0,1,0,0));
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    rd(v); chk("R10 xfer in session", v, st(0,1,0,1,0,0));
    dr_read = 1'b1; tick(1); dr_read = 1'b0;
    rd(v); chk("R7 dr_read clears match", v, st(0,1,0,0,0,0));
    wr(8'h3C);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    rd(v); chk("R3 R10 start ends session", v, st(1,0,0,0,0,0));
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    rd(v); chk("R10 no irq without match", v, st(1,0,0,0,0,0));
    gcall_hit = 1'b1; tick(1); gcall_hit = 1'b0;
    rd(v); chk("R6 general call", v, st(1,1,0,1,1,0));
    is_transmit = 1'b1;
    dr_write = 1'b1; tick(1); dr_write = 1'b0;
    rd(v); chk("R7 dr_write clears matches", v, st(1,1,0,0,0,0));
    is_transmit = 1'b0;
    wr(8'h30);
    rd(v); chk("R8 irq cleared", v, st(1,0,0,0,0,0));
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    rd(v); chk("R3 stop", v, st(0,0,0,0,0,0));

    // R10 fmt 1
    fmt_sel = 1'b1;
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    rd(v); chk("R10 fmt1 xfer irq", v, st(0,1,0,0,0,0));

    // R12 set wins over clear
    rd(v);
    cpu_wr = 1'b1; cpu_wdata = 8'h30; xfer_done = 1'b1;
    tick(1);
    cpu_wr = 1'b0; xfer_done = 1'b0;
    rd(v); chk("R12 set wins", v, st(0,1,0,0,0,0));
    wr(8'h30);
    rd(v); chk("R12 later clear", v, st(0,0,0,0,0,0));

    // R11 acknowledge bit
    is_transmit = 1'b1; ack_sample = 1'b1;
    ack_strobe = 1'b1; tick(1); ack_strobe = 1'b0;
    rd(v); chk("R11 tx ack capture", v, st(0,0,0,0,0,1));
    chk("R11 ack_out", {7'd0, ack_out}, 8'h01);
    is_transmit = 1'b0; ack_sample = 1'b0;
    ack_strobe = 1'b1; tick(1); ack_strobe = 1'b0;
    rd(v); chk("R11 rx strobe ignored", v, st(0,0,0,0,0,1));
    wr(8'h30);
    rd(v); chk("R11 cpu write ack", v, st(0,0,0,0,0,0));
    chk("R11 ack_out low", {7'd0, ack_out}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule